// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the software-facing register file of a hash accelerator. A processor reaches it over a plain 32-bit register bus. The bus has an address, a write strobe, write data and read data that follows the address combinationally. Software loads the source pointer, the digest pointer, the key buffer pointer and the byte count, then writes the job word. That write hands a one-cycle start pulse to the external hash datapath. The datapath reads the programmed values from the block's outputs and answers with a done pulse.

Each pointer register keeps only its implemented address bits. The digest pointer is also held to 8-byte alignment, and the byte count keeps 28 bits. A status word shows whether a job is running and whether one has finished. The finished flag is cleared by writing a one to it, and it drives the interrupt line.

Top module: `hash_regfront`

## Requirements
- R1: After reset every register reads zero: general command (0x10), status (0x1C), source (0x20), digest (0x24), key (0x28), length (0x2C) and job word (0x30). `irq_o` and `job_start_o` are low.
- R2: A write to the source pointer at 0x20 stores only the low `ADDR_BITS` bits (default 31, read-back mask 0x7FFFFFFF). The same value appears on `src_addr_o`.
- R3: A write to the digest pointer at 0x24 uses the source mask and also forces bits [2:0] to zero (default read-back mask 0x7FFFFFF8).
- R4: A write to the byte count at 0x2C stores only bits [27:0].
- R5: The key pointer at 0x28 uses the source mask. The general command register at 0x10 stores all 32 bits.
- R6: A write to the job word at 0x30 while the engine is idle has three effects. It stores all 32 bits of the job word, with algorithm in bits 4, 5, 6 and 10, output byte order in bits 2 and 3, and scatter-gather in bit 18. It raises `job_start_o` for exactly the next cycle. It sets status bit 0 (busy).
- R7: When `job_done_i` is high while busy, status bit 0 clears and status bit 9 (done) sets on that edge.
- R8: Writing 1 to status bit 9 clears it. Writing 0 to bit 9 has no effect. Status bits 1, 2, 12 and 13 always read zero.
- R9: `irq_o` is high exactly while status bit 9 is set.
- R10: A job-word write while busy is ignored. The stored job word is unchanged and no start pulse is produced.
- R11: If a write of 1 to bit 9 lands on the same edge as `job_done_i`, the new completion wins and bit 9 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_addr_o | output | 32 | Programmed source pointer |
| dig_addr_o | output | 32 | Programmed digest pointer |
| key_addr_o | output | 32 | Programmed key pointer |
| data_len_o | output | 32 | Programmed byte count |
| job_word_o | output | 32 | Stored job word |
| job_start_o | output | 1 | One-cycle job launch |
| job_done_i | input | 1 | Completion pulse from the datapath |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two functions can fall on the same clock edge. The datapath's done pulse can coincide with software's write-one-to-clear of the done flag. A job-word write can also coincide with the tail of a running job. The bench uses a datapath stub with a known latency and places a clear write on exactly the edge where the stub's done is sampled. The done flag must then survive with busy dropped. A second launch is issued while the first job is still busy, and the bench checks that the stored job word and the count of start pulses stay unchanged.

// File: rtl/hrf_pkg.sv
`timescale 1ns/1ps
package hrf_pkg;
  localparam int BUS_AW = 8;
  localparam logic [BUS_AW-1:0] OFS_GEN  = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_STS  = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_SRC  = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_DIG  = 8'h24;
  localparam logic [BUS_AW-1:0] OFS_KEY  = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_LEN  = 8'h2C;
  localparam logic [BUS_AW-1:0] OFS_JOB  = 8'h30;
  localparam int STS_BUSY_BIT = 0;
  localparam int STS_DONE_BIT = 9;

  function automatic logic [31:0] low_mask(input int bits);
    logic [63:0] m;
    m = (64'd1 << bits) - 64'd1;
    return m[31:0];
  endfunction
endpackage

// File: rtl/hrf_masked_reg.sv
`timescale 1ns/1ps
module hrf_masked_reg #(
  parameter logic [31:0] KEEP = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  logic [31:0] q_r;
  logic [31:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (wr_en) q_nxt = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (wr_en) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/hrf_job_ctrl.sv
`timescale 1ns/1ps
module hrf_job_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        job_wr,
  input  logic        sts_wr,
  input  logic [31:0] wdata,
  input  logic        job_done_i,
  output logic [31:0] job_word,
  output logic        start,
  output logic        busy,
  output logic        done
);
  import hrf_pkg::*;

  logic [31:0] word_r, word_nxt;
  logic        start_r, start_nxt;
  logic        busy_r, busy_nxt;
  logic        done_r, done_nxt;
  logic        accept;
  logic        finish;
  logic        clear;

  assign accept = job_wr && !busy_r;
  assign finish = job_done_i && busy_r;
  assign clear  = sts_wr && wdata[STS_DONE_BIT];

  always_comb begin
    word_nxt  = accept ? wdata : word_r;
    start_nxt = accept;
    busy_nxt  = busy_r;
    if (accept)      busy_nxt = 1'b1;
    else if (finish) busy_nxt = 1'b0;
    done_nxt = done_r;
    if (finish)     done_nxt = 1'b1;
    else if (clear) done_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_r  <= '0;
      start_r <= 1'b0;
      busy_r  <= 1'b0;
      done_r  <= 1'b0;
    end else begin
      if (accept) word_r <= word_nxt;
      start_r <= start_nxt;
      busy_r  <= busy_nxt;
      done_r  <= done_nxt;
    end
  end

  assign job_word = word_r;
  assign start    = start_r;
  assign busy     = busy_r;
  assign done     = done_r;
endmodule

// File: rtl/hash_regfront.sv
`timescale 1ns/1ps
module hash_regfront #(
  parameter int ADDR_BITS  = 31,
  parameter int LEN_BITS   = 28,
  parameter int ALIGN_BITS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [31:0] src_addr_o,
  output logic [31:0] dig_addr_o,
  output logic [31:0] key_addr_o,
  output logic [31:0] data_len_o,
  output logic [31:0] job_word_o,
  output logic        job_start_o,
  input  logic        job_done_i,
  output logic        irq_o
);
  import hrf_pkg::*;

  localparam logic [31:0] PTR_MASK = low_mask(ADDR_BITS);
  localparam logic [31:0] DIG_MASK = PTR_MASK & ~low_mask(ALIGN_BITS);
  localparam logic [31:0] LEN_MASK = low_mask(LEN_BITS);
  localparam int NREG = 5;
  localparam logic [NREG-1:0][7:0]  REG_OFS  = {OFS_LEN, OFS_KEY, OFS_DIG, OFS_SRC, OFS_GEN};
  localparam logic [NREG-1:0][31:0] REG_KEEP = {LEN_MASK, PTR_MASK, DIG_MASK, PTR_MASK, 32'hFFFF_FFFF};

  logic [NREG-1:0][31:0] reg_q;
  logic        busy_q;
  logic        done_q;
  logic [31:0] status;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    hrf_masked_reg #(.KEEP(REG_KEEP[i])) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_we && (bus_addr == REG_OFS[i])),
      .wdata (bus_wdata),
      .q     (reg_q[i])
    );
  end

  hrf_job_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .job_wr     (bus_we && (bus_addr == OFS_JOB)),
    .sts_wr     (bus_we && (bus_addr == OFS_STS)),
    .wdata      (bus_wdata),
    .job_done_i (job_done_i),
    .job_word   (job_word_o),
    .start      (job_start_o),
    .busy       (busy_q),
    .done       (done_q)
  );

  always_comb begin
    status = '0;
    status[STS_BUSY_BIT] = busy_q;
    status[STS_DONE_BIT] = done_q;
  end

  always_comb begin
    case (bus_addr)
      OFS_GEN: bus_rdata = reg_q[0];
      OFS_STS: bus_rdata = status;
      OFS_SRC: bus_rdata = reg_q[1];
      OFS_DIG: bus_rdata = reg_q[2];
      OFS_KEY: bus_rdata = reg_q[3];
      OFS_LEN: bus_rdata = reg_q[4];
      OFS_JOB: bus_rdata = job_word_o;
      default: bus_rdata = '0;
    endcase
  end

  assign src_addr_o = reg_q[1];
  assign dig_addr_o = reg_q[2];
  assign key_addr_o = reg_q[3];
  assign data_len_o = reg_q[4];
  assign irq_o      = done_q;
endmodule

// File: rtl/hrf_checker.sv
`timescale 1ns/1ps
module hrf_checker #(
  parameter int LEN_BITS = 28
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] dig_addr_o,
  input logic [31:0] data_len_o,
  input logic [31:0] job_word_o,
  input logic        job_start_o,
  input logic        job_done_i,
  input logic        busy,
  input logic        done
);
  logic job_wr, clr_wr;
  assign job_wr = bus_we && (bus_addr == 8'h30);
  assign clr_wr = bus_we && (bus_addr == 8'h1C) && bus_wdata[9];

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    job_start_o |=> !job_start_o);
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (job_wr && !busy) |=> (job_start_o && busy));
  p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && job_done_i && !job_wr) |=> (!busy && done));
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(busy && job_done_i)) |=> !done);
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (job_wr && busy) |=> ($stable(job_word_o) && !job_start_o));
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && busy && job_done_i) |=> done);
  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dig_addr_o[2:0] == 3'b000);
  p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_len_o >> LEN_BITS) == 32'd0);
endmodule

bind hash_regfront hrf_checker #(.LEN_BITS(LEN_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .dig_addr_o  (dig_addr_o),
  .data_len_o  (data_len_o),
  .job_word_o  (job_word_o),
  .job_start_o (job_start_o),
  .job_done_i  (job_done_i),
  .busy        (busy_q),
  .done        (done_q)
);

// File: tb/hash_regfront_tb_top.sv
`timescale 1ns/1ps
module hash_regfront_tb_top;
  localparam int LAT = 4;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] src_addr_o, dig_addr_o, key_addr_o, data_len_o, job_word_o;
  logic        job_start_o;
  logic        job_done_i;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  int start_cnt = 0;
  int stub_cnt;

  hash_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_addr_o(src_addr_o),
    .dig_addr_o(dig_addr_o), .key_addr_o(key_addr_o), .data_len_o(data_len_o),
    .job_word_o(job_word_o), .job_start_o(job_start_o), .job_done_i(job_done_i),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // datapath stub: done arrives a fixed latency after the start pulse
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) stub_cnt <= 0;
    else if (job_start_o) stub_cnt <= LAT;
    else if (stub_cnt != 0) stub_cnt <= stub_cnt - 1;
  end
  assign job_done_i = (stub_cnt == 1);

  always @(posedge clk) if (rst_n && job_start_o) start_cnt++;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'h20, 32'hFFFF_FFFF, 32'h7FFF_FFFF},
    '{8'h24, 32'hFFFF_FFFF, 32'h7FFF_FFF8},
    '{8'h28, 32'hFFFF_FFFF, 32'h7FFF_FFFF},
    '{8'h2C, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
    '{8'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{8'h20, 32'h8000_0123, 32'h0000_0123},
    '{8'h24, 32'h1234_567F, 32'h1234_5678},
    '{8'h2C, 32'hF000_0010, 32'h0000_0010},
    '{8'h28, 32'hC000_0ABC, 32'h4000_0ABC}
  };

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h20:   return "R2";
      8'h24:   return "R3";
      8'h2C:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (VECS[i]) begin
      rd(VECS[i].addr, d); check("R1", d, 32'h0);
    end
    rd(8'h1C, d); check("R1", d, 32'h0);
    rd(8'h30, d); check("R1", d, 32'h0);
    check("R1", {30'd0, irq_o, job_start_o}, 32'h0);

    // masked register table
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, d);
      check(req_of(VECS[i].addr), d, VECS[i].exp);
    end
    check("R2", src_addr_o, 32'h0000_0123);
    check("R3", dig_addr_o, 32'h1234_5678);
    check("R5", key_addr_o, 32'h4000_0ABC);
    check("R4", data_len_o, 32'h0000_0010);

    // R6 launch: SHA-256 (bits 4,6) + big-endian (bit 3) + scatter-gather (bit 18)
    s0 = start_cnt;
    wr(8'h30, 32'h0004_0058);
    check("R6", {31'd0, job_start_o}, 32'h1);
    rd(8'h1C, d); check("R6", d, 32'h0000_0001);
    check("R6", job_word_o, 32'h0004_0058);
    // R10: second launch while busy is ignored
    wr(8'h30, 32'h0000_0060);
    check("R6", {31'd0, job_start_o}, 32'h0);
    rd(8'h30, d); check("R10", d, 32'h0004_0058);
    repeat (LAT + 1) @(negedge clk);
    check("R10", start_cnt - s0, 32'd1);
    // R7 / R9 completion
    rd(8'h1C, d); check("R7", d, 32'h0000_0200);
    check("R9", {31'd0, irq_o}, 32'h1);

    // R8 writing zero to done bit has no effect, other status bits stay zero
    wr(8'h1C, 32'hFFFF_FDFF);
    rd(8'h1C, d); check("R8", d, 32'h0000_0200);
    wr(8'h1C, 32'h0000_0200);
    rd(8'h1C, d); check("R8", d, 32'h0);
    check("R9", {31'd0, irq_o}, 32'h0);

    // R11: clear write lands on the done edge of a second job
    wr(8'h30, 32'h0000_0020);
    repeat (LAT + 1) @(negedge clk);
    rd(8'h1C, d); check("R7", d, 32'h0000_0200);
    wr(8'h30, 32'h0000_0460);       // SHA-384 job, done flag still set
    rd(8'h1C, d); check("R6", d, 32'h0000_0201);
    repeat (LAT - 1) @(negedge clk);
    wr(8'h1C, 32'h0000_0200);        // lands with job_done_i
    rd(8'h1C, d); check("R11", d, 32'h0000_0200);
    check("R11", {31'd0, irq_o}, 32'h1);
    wr(8'h1C, 32'h0000_0200);
    rd(8'h1C, d); check("R8", d, 32'h0);
    rd(8'h30, d); check("R6", d, 32'h0000_0460);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule